// File: doc/BRIEF.md
# Transparent Line Fault Injector

This block sits in series on a single digital signal line and lets a test run corrupt that line with a short burst of logic errors. Such a burst is the digital equivalent of a damped oscillatory disturbance. While idle, the block is invisible: the output follows the input through a multiplexer alone, with no register in the path. When the block is armed, it captures a 64-bit disturbance pattern and a length. It then counts down a delay and takes over the line, sending the captured bits one per clock, most significant bit first. At the end it gives the line back and pulses a done flag for one cycle.

The delay from arming to takeover is a fixed base offset plus a pseudo-random part. The random part is drawn from a free-running 16-bit LFSR and folded into a window that is meant to equal one loop of the software under test, so repeated runs hit every point of that loop with about equal probability. Each instance controls one line, so one injection run disturbs one line.

Top module: `line_fault_injector`

## Requirements
- R1: Outside an injection, `line_o` equals `line_i` combinationally, with no added clock delay, and `active_o` is 0.
- R2: During an injection, `line_o` carries only the pattern bits and does not depend on `line_i`. `active_o` is 1.
- R3: If `arm_i` is sampled high at clock edge k while the block is idle, the first pattern bit appears after edge k+1+D, where D = DLY_BASE + (L mod DLY_WIN). L is the LFSR value held before edge k.
- R4: The LFSR is 16 bits wide and is set to LFSR_SEED (default 16'hACE1, nonzero) by reset. On each clock edge outside reset it shifts left, taking in the bit q[15]^q[13]^q[12]^q[10]. It never holds zero.
- R5: The pattern bits are sent most significant first, one per clock. Bit b of the burst (b = 0 for the first bit) is `pattern_i[63-b]` as captured at the arm edge.
- R6: The burst lasts N = min(`length_i`, 64) cycles. A length above 64 is treated as 64.
- R7: `done_o` is high for exactly one cycle, in the cycle after the last burst bit. With N = 0 it is high in the cycle where the first bit would otherwise have appeared, and no bit is replaced.
- R8: `arm_i` has no effect while a delay or a burst is in progress. The timing and bits of that run are unchanged, and no second run follows.
- R9: A synchronous active-high `rst` drops any pending or running injection, so the line returns to pass-through at the next edge and no burst follows.
- R10: The delay D always lies in DLY_BASE to DLY_BASE+DLY_WIN-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Start one injection run (sampled when idle) |
| pattern_i | input | 64 | Disturbance bits, captured on arming |
| length_i | input | 7 | Number of bits to inject, captured on arming |
| line_i | input | 1 | Line value from the driving side |
| line_o | output | 1 | Line value to the receiving side |
| active_o | output | 1 | High while the line carries pattern bits |
| done_o | output | 1 | One-cycle pulse when a run ends |

## Verification
A stuck or mis-stepped LFSR, or a wrongly folded delay, moves the first corrupted bit off its predicted cycle. The bench tracks the generator from its polynomial and sees this on `active_o` in the very run where it happens. A wrong shift direction or an off-by-one in the length counter shows up on `line_o` at the wrong bit, or as a `done_o` pulse one cycle early or late. If arming is not locked out, a stray `arm_i` leaves `active_o` rising again within one window after `done_o`.

// File: rtl/lfi_pkg.sv
package lfi_pkg;

    localparam int unsigned LFSR_W = 16;
    localparam int unsigned PAT_W  = 64;
    localparam int unsigned LEN_W  = $clog2(PAT_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } inj_state_t;

    typedef struct packed {
        logic [PAT_W-1:0] bits;
        logic [LEN_W-1:0] len;
    } burst_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] q);
        return {q[LFSR_W-2:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
    endfunction

    function automatic int unsigned fold_delay(input logic [LFSR_W-1:0] r,
                                               input int unsigned base,
                                               input int unsigned win);
        return base + (32'(r) % win);
    endfunction

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] n);
        return (32'(n) > PAT_W) ? LEN_W'(PAT_W) : n;
    endfunction

endpackage

// File: rtl/lfi_lfsr.sv
module lfi_lfsr
    import lfi_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] value_o
);

    logic [LFSR_W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= SEED;
        else     q <= lfsr_step(q);
    end

    assign value_o = q;

    p_lfsr_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        q != '0);

    p_lfsr_moves_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> q == lfsr_step($past(q)));

endmodule

// File: rtl/lfi_timer.sv
module lfi_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (load_i)            cnt <= load_val_i;
        else if (run_i && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign zero_o = (cnt == '0);

    p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
        (run_i && !load_i && cnt != 0) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/lfi_shifter.sv
module lfi_shifter
    import lfi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  burst_t           burst_i,
    input  logic             shift_i,
    output logic             bit_o,
    output logic             last_o,
    output logic             empty_o
);

    logic [PAT_W-1:0] sreg;
    logic [LEN_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            left <= '0;
        end else if (load_i) begin
            sreg <= burst_i.bits;
            left <= clamp_len(burst_i.len);
        end else if (shift_i && left != 0) begin
            sreg <= {sreg[PAT_W-2:0], 1'b0};
            left <= left - 1'b1;
        end
    end

    assign bit_o   = sreg[PAT_W-1];
    assign last_o  = (left == LEN_W'(1));
    assign empty_o = (left == '0);

    p_len_bound_r6: assert property (@(posedge clk) disable iff (rst)
        32'(left) <= PAT_W);

    p_msb_first_r5: assert property (@(posedge clk) disable iff (rst)
        (shift_i && !load_i && left > 1) |=> bit_o == $past(sreg[PAT_W-2]));

endmodule

// File: rtl/line_fault_injector.sv
module line_fault_injector
    import lfi_pkg::*;
#(
    parameter int unsigned       DLY_BASE  = 6500,
    parameter int unsigned       DLY_WIN   = 15000,
    parameter logic [15:0]       LFSR_SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        arm_i,
    input  logic [63:0] pattern_i,
    input  logic [6:0]  length_i,
    input  logic        line_i,
    output logic        line_o,
    output logic        active_o,
    output logic        done_o
);

    localparam int unsigned CNT_W = $clog2(DLY_BASE + DLY_WIN + 1);

    inj_state_t        state, state_nx;
    logic [LFSR_W-1:0] rnd;
    logic [CNT_W-1:0]  dly_val;
    logic              take_arm, t_zero, s_bit, s_last, s_empty;
    logic              done_q, done_nx;
    burst_t            burst;

    assign take_arm = (state == ST_IDLE) && arm_i;
    assign dly_val  = CNT_W'(fold_delay(rnd, DLY_BASE, DLY_WIN));
    assign burst    = '{bits: pattern_i, len: length_i};

    lfi_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .value_o (rnd)
    );

    lfi_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (take_arm),
        .load_val_i (dly_val),
        .run_i      (state == ST_WAIT),
        .zero_o     (t_zero)
    );

    lfi_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .load_i  (take_arm),
        .burst_i (burst),
        .shift_i (state == ST_SHIFT),
        .bit_o   (s_bit),
        .last_o  (s_last),
        .empty_o (s_empty)
    );

    always_comb begin
        state_nx = state;
        done_nx  = 1'b0;
        unique case (state)
            ST_IDLE:  if (arm_i) state_nx = ST_WAIT;
            ST_WAIT:  if (t_zero) begin
                          if (s_empty) begin
                              state_nx = ST_IDLE;
                              done_nx  = 1'b1;
                          end else begin
                              state_nx = ST_SHIFT;
                          end
                      end
            ST_SHIFT: if (s_last) begin
                          state_nx = ST_IDLE;
                          done_nx  = 1'b1;
                      end
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            done_q <= 1'b0;
        end else begin
            state  <= state_nx;
            done_q <= done_nx;
        end
    end

    assign active_o = (state == ST_SHIFT);
    assign line_o   = active_o ? s_bit : line_i;
    assign done_o   = done_q;

    p_pass_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !active_o |-> line_o == line_i);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !active_o);

    p_delay_window_r10: assert property (@(posedge clk) disable iff (rst)
        take_arm |-> (32'(dly_val) >= DLY_BASE && 32'(dly_val) < DLY_BASE + DLY_WIN));

    p_arm_locked_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && !s_last) |=> state == ST_SHIFT);

endmodule

// File: tb/line_fault_injector_test.sv
module line_fault_injector_test;

    localparam int unsigned BASE = 20;
    localparam int unsigned WIN  = 37;
    localparam logic [15:0] SEED = 16'hACE1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arm_i = 1'b0;
    logic [63:0] pattern_i = '0;
    logic [6:0]  length_i = '0;
    logic        line_i = 1'b0;
    logic        line_o, active_o, done_o;

    int total = 0;
    int bad   = 0;
    logic [15:0] model = SEED;

    line_fault_injector #(.DLY_BASE(BASE), .DLY_WIN(WIN), .LFSR_SEED(SEED)) uut (
        .clk(clk), .rst(rst), .arm_i(arm_i), .pattern_i(pattern_i),
        .length_i(length_i), .line_i(line_i), .line_o(line_o),
        .active_o(active_o), .done_o(done_o)
    );

    always #5 clk = ~clk;

    // Reference generator from the polynomial stated in R4
    always @(posedge clk) begin
        if (rst) model <= SEED;
        else     model <= {model[14:0], model[15] ^ model[13] ^ model[12] ^ model[10]};
    end

    localparam int NV = 5;
    localparam logic [63:0] VPAT [NV] = '{
        64'hF0F0_CCCC_AAAA_5555, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
        64'hA800_0000_0000_0000, 64'h1234_5678_9ABC_DEF0 };
    localparam logic [6:0] VLEN [NV] = '{7'd64, 7'd1, 7'd0, 7'd5, 7'd100};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic watch_idle(input int cycles, input string req);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk(!active_o && !done_o, req, active_o, 0);
        end
    endtask

    // Runs one injection and checks every cycle against R3/R5/R6/R7/R2
    task automatic inject(input logic [63:0] pat, input logic [6:0] len, input bit rearm);
        int d;
        int n;
        n = (len > 7'd64) ? 64 : int'(len);
        @(negedge clk);
        pattern_i = pat;
        length_i  = len;
        arm_i     = 1'b1;
        d = int'(BASE) + int'(model % 16'(WIN));
        chk(d >= int'(BASE) && d < int'(BASE + WIN), "R10", d, int'(BASE));
        @(negedge clk);
        arm_i     = 1'b0;
        pattern_i = ~pat;
        length_i  = 7'd3;
        for (int i = 0; i <= d; i++) begin
            if (i > 0) @(negedge clk);
            if (rearm && i == 1) arm_i = 1'b1;
            if (rearm && i == 2) arm_i = 1'b0;
            chk(!active_o, "R3", active_o, 0);
        end
        for (int b = 0; b < n; b++) begin
            @(negedge clk);
            line_i = ~pat[63-b];
            #1;
            chk(active_o == 1'b1, "R2", active_o, 1);
            chk(line_o == pat[63-b], "R5", line_o, pat[63-b]);
            chk(!done_o, "R6", done_o, 0);
            if (rearm) arm_i = (b == 0);
        end
        arm_i = 1'b0;
        @(negedge clk);
        chk(!active_o && done_o, "R7", done_o, 1);
        @(negedge clk);
        chk(!done_o, "R7", done_o, 0);
        if (rearm) watch_idle(int'(BASE + WIN) + 3, "R8");
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog expired");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        chk(!active_o && !done_o, "R9", active_o, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: transparent, no clock needed
        for (int i = 0; i < 4; i++) begin
            line_i = i[0];
            #1;
            chk(line_o == line_i && !active_o, "R1", line_o, line_i);
        end

        // Vector table walk: R3 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            inject(VPAT[v], VLEN[v], 1'b0);
            repeat (v) @(negedge clk);
        end

        // R8: arm during delay and burst ignored
        inject(64'hE6C0_0000_0000_0000, 7'd8, 1'b1);

        // R9: reset during the delay drops the run
        @(negedge clk);
        pattern_i = '1;
        length_i  = 7'd10;
        arm_i     = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        line_i = 1'b0;
        #1;
        chk(line_o == 1'b0, "R9", line_o, 0);
        watch_idle(int'(BASE + WIN) + 3, "R9");

        // R4: generator restarted from seed; delay follows the fresh sequence
        inject(64'hC000_0000_0000_0000, 7'd2, 1'b0);

        // R1 again after all activity
        line_i = 1'b1;
        #1;
        chk(line_o == 1'b1, "R1", line_o, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule